// File: doc/BRIEF.md
# Interrupt Pending State Bank

This block keeps the pending state of a bank of interrupt lines, each configured as edge or level triggered. For every line a pending latch is stored apart from the live input level. An edge line latches on a rising input. A level line latches only when the guest sets it by software. The pending state the guest sees combines the latch with the level of any level line. Activation pulses coming from the delivery logic clear latches.

Two register ports reach the state. The guest port follows the usual write-1-to-set and write-1-to-clear pending registers and a write-1-to-clear status register. The save/restore port shows the raw state instead, so that a hypervisor can capture a controller and rebuild it exactly. On that port the set-pending offsets read and write the latch bits directly, the clear-pending offsets read as zero and ignore writes, and a status write loads its value. Accesses on this port are refused with an error while the attached CPUs are flagged as running. Both ports also read a line-level snapshot word.

Top module: `pend_state_bank`

## Requirements
- R1: A rising edge on an edge-triggered line (input high now, low on the previous clock) sets its latch. The latch stays set after the line falls, until an activation pulse or a guest clear-pending write (register kind 2'b01) clears it.
- R2: A level-triggered line never latches from its input. Its latch is set only by a set-pending write (kind 2'b00) and cleared by a clear-pending write or an activation. Its pending state is latch OR input, so it stays pending while the input is high.
- R3: When a set-pending write and an activation or clear reach the same bit in the same cycle, the bit ends up set.
- R4: A guest read of kind 2'b00 or 2'b01 returns the pending state: the latch for edge lines, and latch OR input for level lines.
- R5: A save/restore access of kind 2'b00 reads the raw latch bits, or replaces the whole latch word with the written value.
- R6: A save/restore access of kind 2'b01 reads zero, and a write there changes nothing.
- R7: The status register (kind 2'b10, word index ignored) has 2 valid bits; the upper bits read zero. Bit 0 is set by a guest access to a word-indexed kind beyond the bank, and bit 1 by a guest write to the level word. A guest write clears the bits written as 1. A save/restore write loads bits 1:0 from the data.
- R8: The line-level word (kind 2'b11) returns input levels with bit n meaning line 32*word+n. Lines 0 to 15 always read 0, and writes to this word change no state.
- R9: Word indices at or beyond NUM_IRQS/32 read zero and ignore writes.
- R10: While cpus_running_i is high, a save/restore access returns s_err_o=1 with data 0 and has no effect.
- R11: Reset clears the latches, the status and the edge history. Both ports are always ready, and the response (rvalid, rdata) appears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line_i | input | NUM_IRQS | Interrupt input levels |
| irq_edge_i | input | NUM_IRQS | 1 = edge triggered, 0 = level triggered |
| irq_activate_i | input | NUM_IRQS | Activation pulses, clear latches |
| cpus_running_i | input | 1 | Attached CPUs running; blocks save/restore port |
| g_valid_i | input | 1 | Guest access request |
| g_ready_o | output | 1 | Guest port ready (always 1) |
| g_write_i | input | 1 | Guest write (1) or read (0) |
| g_kind_i | input | 2 | 00 set-pend, 01 clear-pend, 10 status, 11 level |
| g_word_i | input | 5 | Word index (lines 32*word..+31) |
| g_wdata_i | input | 32 | Guest write data |
| g_rvalid_o | output | 1 | Guest response valid |
| g_rdata_o | output | 32 | Guest read data |
| s_valid_i | input | 1 | Save/restore access request |
| s_ready_o | output | 1 | Save/restore port ready (always 1) |
| s_write_i | input | 1 | Save/restore write (1) or read (0) |
| s_kind_i | input | 2 | Same encoding as g_kind_i |
| s_word_i | input | 5 | Word index |
| s_wdata_i | input | 32 | Save/restore write data |
| s_rvalid_o | output | 1 | Save/restore response valid |
| s_rdata_o | output | 32 | Save/restore read data |
| s_err_o | output | 1 | Access refused (CPUs running) |

## Verification
The assertions check on every cycle that responses arrive one cycle after acceptance and that save/restore accesses are refused while the CPUs run. They also check that the raw clear offsets and out-of-range words read zero, that reserved status bits stay zero, and that any rising edge on an edge line lands in its latch. Only the bench scenarios can show the interplay over time. This covers a level line that stays pending through a clear and an activation, a set beating a same-cycle activation, the differing status write rules of the two ports, the masking of the low sixteen lines in the level word, and a raw latch restore that survives in the guest view.

// File: rtl/pend_bank_pkg.sv
// Shared constants and register-kind encoding for the pending state bank.
// Assumes 32-bit register words and at most 32 words (1024 lines).
package pend_bank_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int STAT_W    = 2;
    localparam int SGI_LINES = 16;
    localparam int STAT_OOR  = 0;   // guest access beyond the bank
    localparam int STAT_ROWR = 1;   // guest write to the read-only level word

    typedef enum logic [1:0] {
        KIND_SETPEND = 2'b00,
        KIND_CLRPEND = 2'b01,
        KIND_STATUS  = 2'b10,
        KIND_LEVEL   = 2'b11
    } reg_kind_e;
endpackage

// File: rtl/pend_edge_detect.sv
// Rising-edge detector for edge-triggered lines.
// Keeps the previous-clock value of every input line; reports a rise only
// for lines configured as edge triggered. History is cleared by reset.
module pend_edge_detect #(
    parameter int NUM_IRQS = 96
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] line_i,
    input  logic [NUM_IRQS-1:0] edge_i,
    output logic [NUM_IRQS-1:0] rise_o
);
    logic [NUM_IRQS-1:0] line_q;

    // Register the line levels for comparison on the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_i;
    end

    assign rise_o = line_i & ~line_q & edge_i;
endmodule

// File: rtl/pend_access_decode.sv
// Word selector for one register port.
// Produces a one-hot select of the addressed word when the access is valid
// and in range; an out-of-range index yields an all-zero select.
module pend_access_decode import pend_bank_pkg::*; #(
    parameter int NUM_WORDS = 3
) (
    input  logic                 valid_i,
    input  logic [ADDR_W-1:0]    word_i,
    output logic [NUM_WORDS-1:0] sel_o
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
        assign sel_o[w] = valid_i && (word_i == ADDR_W'(w));
    end
endmodule

// File: rtl/pend_latch_array.sv
// Pending latch storage, one 32-bit word per generate slice.
// Per cycle: a raw load of a word replaces it; otherwise set bits win over
// clear bits. Assumes at most one raw load per word per cycle.
module pend_latch_array import pend_bank_pkg::*; #(
    parameter int NUM_IRQS  = 96,
    parameter int NUM_WORDS = NUM_IRQS / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQS-1:0]  set_i,
    input  logic [NUM_IRQS-1:0]  clr_i,
    input  logic [NUM_WORDS-1:0] load_word_i,
    input  logic [WORD_W-1:0]    load_data_i,
    output logic [NUM_IRQS-1:0]  latch_o
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;

        // Update one latch word: raw load, else set-dominant set/clear.
        always_ff @(posedge clk) begin
            if (!rst_n)              word_q <= '0;
            else if (load_word_i[w]) word_q <= load_data_i;
            else                     word_q <= (word_q & ~clr_i[w*WORD_W +: WORD_W])
                                               | set_i[w*WORD_W +: WORD_W];
        end

        assign latch_o[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/pend_state_bank.sv
// Interrupt pending state bank with a guest port and a save/restore port.
// Assumes NUM_IRQS is a multiple of 32 between 64 and 1024. Both ports are
// always ready; responses are registered and appear one cycle after accept.
// Priority inside a cycle: raw latch load > set > clear/activation.
module pend_state_bank import pend_bank_pkg::*; #(
    parameter int NUM_IRQS = 96
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] irq_line_i,
    input  logic [NUM_IRQS-1:0] irq_edge_i,
    input  logic [NUM_IRQS-1:0] irq_activate_i,
    input  logic                cpus_running_i,
    input  logic                g_valid_i,
    output logic                g_ready_o,
    input  logic                g_write_i,
    input  logic [1:0]          g_kind_i,
    input  logic [4:0]          g_word_i,
    input  logic [31:0]         g_wdata_i,
    output logic                g_rvalid_o,
    output logic [31:0]         g_rdata_o,
    input  logic                s_valid_i,
    output logic                s_ready_o,
    input  logic                s_write_i,
    input  logic [1:0]          s_kind_i,
    input  logic [4:0]          s_word_i,
    input  logic [31:0]         s_wdata_i,
    output logic                s_rvalid_o,
    output logic [31:0]         s_rdata_o,
    output logic                s_err_o
);
    localparam int NUM_WORDS = NUM_IRQS / WORD_W;
    localparam logic [NUM_IRQS-1:0] SGI_MASK =
        {{(NUM_IRQS-SGI_LINES){1'b0}}, {SGI_LINES{1'b1}}};

    logic [NUM_WORDS-1:0] g_sel, s_sel, load_word;
    logic [NUM_IRQS-1:0]  rise, latch, pending, level_view;
    logic [NUM_IRQS-1:0]  g_set_bits, g_clr_bits, load_bits;
    logic                 s_ok, g_wr_set, g_wr_clr, s_load;
    logic [STAT_W-1:0]    status_q, stat_hw, stat_w1c;
    logic [WORD_W-1:0]    pend_g, lvl_g, latch_s, lvl_s, g_rd_next, s_rd_next;

    assign g_ready_o = 1'b1;
    assign s_ready_o = 1'b1;
    assign s_ok      = s_valid_i && !cpus_running_i;
    assign g_wr_set  = g_write_i && (g_kind_i == KIND_SETPEND);
    assign g_wr_clr  = g_write_i && (g_kind_i == KIND_CLRPEND);
    assign s_load    = s_ok && s_write_i && (s_kind_i == KIND_SETPEND);

    pend_edge_detect #(.NUM_IRQS(NUM_IRQS)) i_edge (
        .clk(clk), .rst_n(rst_n), .line_i(irq_line_i),
        .edge_i(irq_edge_i), .rise_o(rise)
    );

    pend_access_decode #(.NUM_WORDS(NUM_WORDS)) i_gdec (
        .valid_i(g_valid_i), .word_i(g_word_i), .sel_o(g_sel)
    );

    pend_access_decode #(.NUM_WORDS(NUM_WORDS)) i_sdec (
        .valid_i(s_valid_i), .word_i(s_word_i), .sel_o(s_sel)
    );

    // Expand word-level write strobes into per-line masks.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
        assign g_set_bits[w*WORD_W +: WORD_W] = (g_wr_set && g_sel[w]) ? g_wdata_i : '0;
        assign g_clr_bits[w*WORD_W +: WORD_W] = (g_wr_clr && g_sel[w]) ? g_wdata_i : '0;
        assign load_word[w]                   = s_load && s_sel[w];
        assign load_bits[w*WORD_W +: WORD_W]  = {WORD_W{load_word[w]}};
    end

    pend_latch_array #(.NUM_IRQS(NUM_IRQS), .NUM_WORDS(NUM_WORDS)) i_latch (
        .clk(clk), .rst_n(rst_n),
        .set_i(g_set_bits | rise),
        .clr_i(g_clr_bits | irq_activate_i),
        .load_word_i(load_word), .load_data_i(s_wdata_i),
        .latch_o(latch)
    );

    assign pending    = latch | (irq_line_i & ~irq_edge_i);
    assign level_view = irq_line_i & ~SGI_MASK;

    // Select the addressed word of each view for both ports.
    always_comb begin
        pend_g  = '0;
        lvl_g   = '0;
        latch_s = '0;
        lvl_s   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (g_sel[w]) begin
                pend_g = pending[w*WORD_W +: WORD_W];
                lvl_g  = level_view[w*WORD_W +: WORD_W];
            end
            if (s_sel[w]) begin
                latch_s = latch[w*WORD_W +: WORD_W];
                lvl_s   = level_view[w*WORD_W +: WORD_W];
            end
        end
    end

    // Form guest and save/restore read data by register kind.
    always_comb begin
        case (g_kind_i)
            KIND_SETPEND, KIND_CLRPEND: g_rd_next = pend_g;
            KIND_STATUS:                g_rd_next = {{(WORD_W-STAT_W){1'b0}}, status_q};
            default:                    g_rd_next = lvl_g;
        endcase
        case (s_kind_i)
            KIND_SETPEND: s_rd_next = latch_s;
            KIND_CLRPEND: s_rd_next = '0;
            KIND_STATUS:  s_rd_next = {{(WORD_W-STAT_W){1'b0}}, status_q};
            default:      s_rd_next = lvl_s;
        endcase
    end

    // Derive hardware-set and guest write-1-to-clear status bits.
    always_comb begin
        stat_hw            = '0;
        stat_hw[STAT_OOR]  = g_valid_i && (g_kind_i != KIND_STATUS) && !(|g_sel);
        stat_hw[STAT_ROWR] = g_valid_i && g_write_i && (g_kind_i == KIND_LEVEL);
        stat_w1c = (g_valid_i && g_write_i && g_kind_i == KIND_STATUS)
                   ? g_wdata_i[STAT_W-1:0] : '0;
    end

    // Status register: raw load from save/restore, else set-dominant W1C.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (s_ok && s_write_i && s_kind_i == KIND_STATUS)
            status_q <= s_wdata_i[STAT_W-1:0];
        else
            status_q <= (status_q & ~stat_w1c) | stat_hw;
    end

    // Register the guest port response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_rvalid_o <= 1'b0;
            g_rdata_o  <= '0;
        end else begin
            g_rvalid_o <= g_valid_i;
            g_rdata_o  <= (g_valid_i && !g_write_i) ? g_rd_next : '0;
        end
    end

    // Register the save/restore port response, flagging refused accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid_o <= 1'b0;
            s_rdata_o  <= '0;
            s_err_o    <= 1'b0;
        end else begin
            s_rvalid_o <= s_valid_i;
            s_err_o    <= s_valid_i && cpus_running_i;
            s_rdata_o  <= (s_ok && !s_write_i) ? s_rd_next : '0;
        end
    end

    AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & ~load_bits)) |=> ((latch & $past(rise & ~load_bits)) == $past(rise & ~load_bits))); // R1
    AST_GUEST_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        g_valid_i |=> g_rvalid_o); // R11
    AST_SR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && cpus_running_i) |=> (s_err_o && s_rvalid_o && s_rdata_o == '0)); // R10
    AST_SR_CLR_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && !s_write_i && s_kind_i == KIND_CLRPEND) |=> (s_rdata_o == '0)); // R6
    AST_OOR_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (g_valid_i && !g_write_i && g_kind_i != KIND_STATUS
         && {1'b0, g_word_i} >= (ADDR_W+1)'(NUM_WORDS)) |=> (g_rdata_o == '0)); // R9
    AST_STAT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && !s_write_i && s_kind_i == KIND_STATUS) |=> (s_rdata_o[WORD_W-1:STAT_W] == '0)); // R7
endmodule

// File: tb/test_pend_state_bank.sv
// Bench: a vector table walked by one loop, then directed corner cases.
module test_pend_state_bank;
    localparam int N = 96;
    localparam logic [1:0] KS = 2'b00, KC = 2'b01, KT = 2'b10, KL = 2'b11;

    typedef struct packed {
        logic [31:0] line1;
        logic        sr;
        logic        wr;
        logic [1:0]  kind;
        logic [4:0]  word;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{32'h0,        1'b0, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h0,        4'd11}, // R11
        '{32'h1,        1'b0, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h1,        4'd1},  // R1
        '{32'h00010000, 1'b0, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h00010001, 4'd2},  // R2
        '{32'h00010000, 1'b0, 1'b1, KC, 5'd1, 32'h00010001, 1'b0, 32'h0,        4'd2},
        '{32'h00010000, 1'b0, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h00010000, 4'd2},  // R2
        '{32'h00010000, 1'b1, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h0,        4'd5},  // R5
        '{32'h0,        1'b0, 1'b1, KS, 5'd1, 32'h00020002, 1'b0, 32'h0,        4'd4},
        '{32'h0,        1'b0, 1'b0, KC, 5'd1, 32'h0,        1'b1, 32'h00020002, 4'd4},  // R4
        '{32'h00020000, 1'b1, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h00020002, 4'd5},  // R5
        '{32'h00020000, 1'b1, 1'b1, KC, 5'd1, 32'hFFFFFFFF, 1'b0, 32'h0,        4'd6},
        '{32'h00020000, 1'b1, 1'b0, KC, 5'd1, 32'h0,        1'b1, 32'h0,        4'd6},  // R6
        '{32'h00020000, 1'b1, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h00020002, 4'd6},  // R6
        '{32'h00020000, 1'b1, 1'b1, KS, 5'd1, 32'h80000004, 1'b0, 32'h0,        4'd5},
        '{32'h00020000, 1'b0, 1'b0, KS, 5'd1, 32'h0,        1'b1, 32'h80020004, 4'd5},  // R5
        '{32'h00020000, 1'b0, 1'b0, KL, 5'd1, 32'h0,        1'b1, 32'h00020000, 4'd8},  // R8
        '{32'h0,        1'b0, 1'b1, KS, 5'd5, 32'hFFFFFFFF, 1'b0, 32'h0,        4'd9},
        '{32'h0,        1'b0, 1'b0, KS, 5'd5, 32'h0,        1'b1, 32'h0,        4'd9},  // R9
        '{32'h0,        1'b0, 1'b0, KT, 5'd0, 32'h0,        1'b1, 32'h1,        4'd7},  // R7
        '{32'h0,        1'b0, 1'b1, KT, 5'd0, 32'h1,        1'b0, 32'h0,        4'd7},
        '{32'h0,        1'b0, 1'b0, KT, 5'd0, 32'h0,        1'b1, 32'h0,        4'd7},  // R7
        '{32'h0,        1'b1, 1'b1, KT, 5'd0, 32'hFFFFFFFF, 1'b0, 32'h0,        4'd7},
        '{32'h0,        1'b1, 1'b0, KT, 5'd0, 32'h0,        1'b1, 32'h3,        4'd7},  // R7
        '{32'h0,        1'b0, 1'b1, KT, 5'd0, 32'h2,        1'b0, 32'h0,        4'd7},
        '{32'h0,        1'b0, 1'b0, KT, 5'd0, 32'h0,        1'b1, 32'h1,        4'd7},  // R7
        '{32'h0,        1'b0, 1'b1, KL, 5'd1, 32'hFFFFFFFF, 1'b0, 32'h0,        4'd8},
        '{32'h0,        1'b0, 1'b0, KT, 5'd0, 32'h0,        1'b1, 32'h3,        4'd7},  // R7
        '{32'h0,        1'b0, 1'b0, KL, 5'd1, 32'h0,        1'b1, 32'h0,        4'd8}   // R8
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] irq_line = '0, irq_act = '0;
    logic [N-1:0] irq_edge = {32'h0, 32'h0000FFFF, 32'hFFFFFFFF};
    logic running = 1'b0;
    logic g_valid = 1'b0, g_write = 1'b0, s_valid = 1'b0, s_write = 1'b0;
    logic [1:0] g_kind = '0, s_kind = '0;
    logic [4:0] g_word = '0, s_word = '0;
    logic [31:0] g_wdata = '0, s_wdata = '0;
    logic g_ready, g_rvalid, s_ready, s_rvalid, s_err;
    logic [31:0] g_rdata, s_rdata;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pend_state_bank #(.NUM_IRQS(N)) i_pend_state_bank (
        .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line), .irq_edge_i(irq_edge),
        .irq_activate_i(irq_act), .cpus_running_i(running),
        .g_valid_i(g_valid), .g_ready_o(g_ready), .g_write_i(g_write),
        .g_kind_i(g_kind), .g_word_i(g_word), .g_wdata_i(g_wdata),
        .g_rvalid_o(g_rvalid), .g_rdata_o(g_rdata),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_write_i(s_write),
        .s_kind_i(s_kind), .s_word_i(s_word), .s_wdata_i(s_wdata),
        .s_rvalid_o(s_rvalid), .s_rdata_o(s_rdata), .s_err_o(s_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic sr, input logic wr, input logic [1:0] kind,
                       input logic [4:0] word, input logic [31:0] wdata,
                       input logic [N-1:0] act, output logic [31:0] rd, output logic er);
        @(negedge clk);
        if (sr) begin
            s_valid = 1'b1; s_write = wr; s_kind = kind; s_word = word; s_wdata = wdata;
        end else begin
            g_valid = 1'b1; g_write = wr; g_kind = kind; g_word = word; g_wdata = wdata;
        end
        irq_act = act;
        @(negedge clk);
        g_valid = 1'b0; s_valid = 1'b0; irq_act = '0;
        rd = sr ? s_rdata : g_rdata;
        er = s_err;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        logic [N-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 rvalid idle", {31'b0, g_rvalid}, 32'h0);
        check("R11 ready", {30'b0, g_ready, s_ready}, 32'h3);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_line[63:32] = VECS[i].line1;
            acc(VECS[i].sr, VECS[i].wr, VECS[i].kind, VECS[i].word, VECS[i].wdata, '0, rd, er);
            if (VECS[i].chk)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R8 / R1: low sixteen lines masked in the level word; edges latch.
        @(negedge clk);
        irq_line[31:0] = 32'hFFFFFFFF;
        acc(0, 0, KL, 5'd0, 0, '0, rd, er);
        check("R8 sgi masked", rd, 32'hFFFF0000);
        acc(0, 0, KS, 5'd0, 0, '0, rd, er);
        check("R1 word0 latched", rd, 32'hFFFFFFFF);
        a = '0; a[3] = 1'b1;
        acc(0, 0, KT, 5'd0, 0, a, rd, er);
        acc(0, 0, KS, 5'd0, 0, '0, rd, er);
        check("R1 activation clears", rd, 32'hFFFFFFF7);
        // R3: set and activation on the same bit in one cycle.
        acc(0, 1, KS, 5'd0, 32'h8, a, rd, er);
        acc(0, 0, KS, 5'd0, 0, '0, rd, er);
        check("R3 set wins", rd, 32'hFFFFFFFF);
        check("R11 rvalid after access", {31'b0, g_rvalid}, 32'h1);
        @(negedge clk);
        check("R11 rvalid drops", {31'b0, g_rvalid}, 32'h0);

        // R2: level line held high survives activation of its latch.
        irq_line[64] = 1'b1;
        acc(0, 1, KS, 5'd2, 32'h1, '0, rd, er);
        a = '0; a[64] = 1'b1;
        acc(0, 0, KT, 5'd0, 0, a, rd, er);
        acc(1, 0, KS, 5'd2, 0, '0, rd, er);
        check("R2 latch cleared", rd, 32'h0);
        acc(0, 0, KS, 5'd2, 0, '0, rd, er);
        check("R2 level holds pending", rd, 32'h1);
        @(negedge clk);
        irq_line[64] = 1'b0;
        acc(0, 0, KS, 5'd2, 0, '0, rd, er);
        check("R2 level released", rd, 32'h0);

        // R10: refused while CPUs run.
        running = 1'b1;
        acc(1, 1, KS, 5'd2, 32'hFFFFFFFF, '0, rd, er);
        check("R10 write err", {31'b0, er}, 32'h1);
        acc(1, 0, KS, 5'd0, 0, '0, rd, er);
        check("R10 read err", {31'b0, er}, 32'h1);
        check("R10 read data", rd, 32'h0);
        running = 1'b0;
        acc(0, 0, KS, 5'd2, 0, '0, rd, er);
        check("R10 write had no effect", rd, 32'h0);

        // R11: reset in mid-run clears state.
        @(negedge clk);
        irq_line = '0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R11 rvalid in reset", {31'b0, g_rvalid}, 32'h0);
        acc(0, 0, KS, 5'd0, 0, '0, rd, er);
        check("R11 latch cleared", rd, 32'h0);
        acc(0, 0, KT, 5'd0, 0, '0, rd, er);
        check("R11 status cleared", rd, 32'h0);
        acc(1, 0, KS, 5'd1, 0, '0, rd, er);
        check("R11 raw latch cleared", rd, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule